// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a small, fully associative address-translation cache. Every entry maps two neighbouring virtual pages, an even one and an odd one, onto two independent physical frames. An entry holds a virtual tag, a page-size mask, an 8-bit address-space identifier, a global flag, and a frame number plus valid and dirty flags for each of its two halves. A lookup presents a virtual address, the current address-space identifier and a read/write flag. All entries are compared in parallel. One clock later the block returns a result code, the physical address and the read and write permissions.

Entries are loaded through an indexed write port that takes effect at the clock edge. Page sizes vary per entry, from a pair of minimum-size pages upward, through the stored mask. Refill policy and the choice of victim belong to the surrounding logic.

Top module: `tlb_pair_lookup`

## Requirements
- R1: While `rst` is high, `rsp_valid` goes low and every entry is cleared: tag 0, mask 0, identifier 0, global 0, frames 0, and both halves invalid and clean. A lookup that hits a cleared entry therefore returns INVALID.
- R2: An entry hits only when the address and the tag agree on every bit outside the effective mask, and the entry's global flag is set or its identifier equals `req_asid`.
- R3: The effective mask is the stored mask ORed with ones in bits 0 to MIN_PG_SHIFT (default bits 0..12). The smallest mapping is therefore two 4 KiB pages, and larger pages follow from the stored mask (for example 0x6000 gives 16 KiB, 0x1E000 gives 64 KiB and 0x1FFE000 gives 16 MiB pages).
- R4: The half is picked by the address bit at the top set position of the effective mask: 0 selects the even half (frame 0) and 1 selects the odd half (frame 1).
- R5: If the selected half is not valid, the code is INVALID (3'b101) for both reads and writes.
- R6: A write to a valid half whose dirty flag is clear returns DIRTY (3'b100). A read of such a half returns MATCH with `rsp_rd`=1 and `rsp_wr`=0.
- R7: On MATCH the code is 3'b000, `rsp_pa` is the selected frame ORed with the address bits under the effective mask shifted right by one, `rsp_rd` is 1, and `rsp_wr` equals the half's dirty flag.
- R8: If no entry hits, the code is NOMATCH (3'b110). Whenever the code is not MATCH, `rsp_pa`, `rsp_rd` and `rsp_wr` are 0. The code 3'b111 (bad address) is never produced.
- R9: When several entries hit, the entry with the lowest index decides the result.
- R10: `rsp_valid` rises one cycle after a cycle with `req_valid` high and is low one cycle after a cycle with `req_valid` low.
- R11: When `wr_en` is high, entry `wr_idx` is replaced at the clock edge. A lookup issued in that same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write an entry this cycle |
| wr_idx | input | IDX_W | Entry index to write |
| wr_tag | input | VA_W | Virtual tag of the page pair |
| wr_mask | input | VA_W | Page-size mask |
| wr_asid | input | ASID_W | Entry address-space identifier |
| wr_global | input | 1 | Skip the identifier compare |
| wr_pfn0 | input | PA_W | Even-half frame base |
| wr_pfn1 | input | PA_W | Odd-half frame base |
| wr_v0 | input | 1 | Even half valid |
| wr_v1 | input | 1 | Odd half valid |
| wr_d0 | input | 1 | Even half writable (dirty) |
| wr_d1 | input | 1 | Odd half writable (dirty) |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Current address-space identifier |
| req_write | input | 1 | 1 for a store access |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | PA_W | Physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_code | output | 3 | Result code |

## Verification
An entry write and a lookup of the same address can arrive in the same cycle. The bench issues both together on a fresh entry, expects NOMATCH because the lookup sees the old contents, and then repeats the lookup alone, expecting the new translation. It also places two identical entries at different indices so that both hit in one cycle, and checks that the frame of the lower index is returned.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
  // result codes: 3-bit two's complement of 0, -1, -2, -3, -4
  typedef enum logic [2:0] {
    RES_MATCH   = 3'b000,
    RES_DIRTY   = 3'b100,
    RES_INVALID = 3'b101,
    RES_NOMATCH = 3'b110,
    RES_BADADDR = 3'b111
  } tlb_res_e;
endpackage

// File: rtl/tlb_pair_store.sv
module tlb_pair_store #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_tag,
  input  logic [VA_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PA_W-1:0]   wr_pfn0,
  input  logic [PA_W-1:0]   wr_pfn1,
  input  logic [1:0]        wr_valid,
  input  logic [1:0]        wr_dirty,
  output logic [VA_W-1:0]   ent_tag   [ENTRIES],
  output logic [VA_W-1:0]   ent_mask  [ENTRIES],
  output logic [ASID_W-1:0] ent_asid  [ENTRIES],
  output logic              ent_glob  [ENTRIES],
  output logic [PA_W-1:0]   ent_pfn0  [ENTRIES],
  output logic [PA_W-1:0]   ent_pfn1  [ENTRIES],
  output logic [1:0]        ent_valid [ENTRIES],
  output logic [1:0]        ent_dirty [ENTRIES]
);
  // register file: every entry is read in parallel, so no RAM macro fits
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_tag[e]   <= '0;
        ent_mask[e]  <= '0;
        ent_asid[e]  <= '0;
        ent_glob[e]  <= 1'b0;
        ent_pfn0[e]  <= '0;
        ent_pfn1[e]  <= '0;
        ent_valid[e] <= 2'b00;
        ent_dirty[e] <= 2'b00;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        ent_tag[e]   <= wr_tag;
        ent_mask[e]  <= wr_mask;
        ent_asid[e]  <= wr_asid;
        ent_glob[e]  <= wr_global;
        ent_pfn0[e]  <= wr_pfn0;
        ent_pfn1[e]  <= wr_pfn1;
        ent_valid[e] <= wr_valid;
        ent_dirty[e] <= wr_dirty;
      end
    end
  end
endmodule

// File: rtl/tlb_pair_match.sv
module tlb_pair_match
  import tlb_pair_pkg::*;
#(
  parameter int ENTRIES      = 16,
  parameter int VA_W         = 32,
  parameter int PA_W         = 32,
  parameter int ASID_W       = 8,
  parameter int MIN_PG_SHIFT = 12,
  parameter int IDX_W        = $clog2(ENTRIES)
) (
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   ent_tag   [ENTRIES],
  input  logic [VA_W-1:0]   ent_mask  [ENTRIES],
  input  logic [ASID_W-1:0] ent_asid  [ENTRIES],
  input  logic              ent_glob  [ENTRIES],
  input  logic [PA_W-1:0]   ent_pfn0  [ENTRIES],
  input  logic [PA_W-1:0]   ent_pfn1  [ENTRIES],
  input  logic [1:0]        ent_valid [ENTRIES],
  input  logic [1:0]        ent_dirty [ENTRIES],
  output tlb_res_e          res_code,
  output logic [PA_W-1:0]   res_pa,
  output logic              res_rd,
  output logic              res_wr
);
  localparam int LOW_BITS = MIN_PG_SHIFT + 1;
  localparam logic [VA_W-1:0] LOW_MASK = {{(VA_W-LOW_BITS){1'b0}}, {LOW_BITS{1'b1}}};

  logic [ENTRIES-1:0] hit;
  logic [ENTRIES-1:0] odd;
  logic [VA_W-1:0]    offs [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [VA_W-1:0] effm;
    assign effm    = ent_mask[e] | LOW_MASK;
    assign hit[e]  = ((req_va & ~effm) == (ent_tag[e] & ~effm)) &&
                     (ent_glob[e] || ent_asid[e] == req_asid);
    assign odd[e]  = |(req_va & effm & ~(effm >> 1));
    assign offs[e] = req_va & (effm >> 1);
  end

  logic             any_hit;
  logic [IDX_W-1:0] sel;
  always_comb begin
    any_hit = 1'b0;
    sel     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        sel     = IDX_W'(i);
      end
    end
  end

  logic            h_odd, h_valid, h_dirty;
  logic [PA_W-1:0] h_frame;
  always_comb begin
    h_odd   = odd[sel];
    h_valid = ent_valid[sel][h_odd];
    h_dirty = ent_dirty[sel][h_odd];
    h_frame = h_odd ? ent_pfn1[sel] : ent_pfn0[sel];
    res_code = RES_MATCH;
    res_pa   = '0;
    res_rd   = 1'b0;
    res_wr   = 1'b0;
    if (!any_hit) begin
      res_code = RES_NOMATCH;
    end else if (!h_valid) begin
      res_code = RES_INVALID;
    end else if (req_write && !h_dirty) begin
      res_code = RES_DIRTY;
    end else begin
      res_pa = h_frame | PA_W'(offs[sel]);
      res_rd = 1'b1;
      res_wr = h_dirty;
    end
  end
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pair_pkg::*;
#(
  parameter int ENTRIES      = 16,
  parameter int VA_W         = 32,
  parameter int PA_W         = 32,
  parameter int ASID_W       = 8,
  parameter int MIN_PG_SHIFT = 12,
  parameter int IDX_W        = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_tag,
  input  logic [VA_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PA_W-1:0]   wr_pfn0,
  input  logic [PA_W-1:0]   wr_pfn1,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic              wr_d0,
  input  logic              wr_d1,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic [2:0]        rsp_code
);
  logic [VA_W-1:0]   ent_tag   [ENTRIES];
  logic [VA_W-1:0]   ent_mask  [ENTRIES];
  logic [ASID_W-1:0] ent_asid  [ENTRIES];
  logic              ent_glob  [ENTRIES];
  logic [PA_W-1:0]   ent_pfn0  [ENTRIES];
  logic [PA_W-1:0]   ent_pfn1  [ENTRIES];
  logic [1:0]        ent_valid [ENTRIES];
  logic [1:0]        ent_dirty [ENTRIES];

  tlb_pair_store #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1),
    .wr_valid({wr_v1, wr_v0}), .wr_dirty({wr_d1, wr_d0}),
    .ent_tag(ent_tag), .ent_mask(ent_mask), .ent_asid(ent_asid), .ent_glob(ent_glob),
    .ent_pfn0(ent_pfn0), .ent_pfn1(ent_pfn1), .ent_valid(ent_valid), .ent_dirty(ent_dirty)
  );

  tlb_res_e        c_code;
  logic [PA_W-1:0] c_pa;
  logic            c_rd, c_wr;

  tlb_pair_match #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W),
    .MIN_PG_SHIFT(MIN_PG_SHIFT), .IDX_W(IDX_W)
  ) u_match (
    .req_va(req_va), .req_asid(req_asid), .req_write(req_write),
    .ent_tag(ent_tag), .ent_mask(ent_mask), .ent_asid(ent_asid), .ent_glob(ent_glob),
    .ent_pfn0(ent_pfn0), .ent_pfn1(ent_pfn1), .ent_valid(ent_valid), .ent_dirty(ent_dirty),
    .res_code(c_code), .res_pa(c_pa), .res_rd(c_rd), .res_wr(c_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_code  <= RES_NOMATCH;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa   <= c_pa;
        rsp_rd   <= c_rd;
        rsp_wr   <= c_wr;
        rsp_code <= c_code;
      end
    end
  end
endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_rd,
  input logic            rsp_wr,
  input logic [2:0]      rsp_code
);
  // R10: response follows request by one cycle
  a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r10_idle_after_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R8: failures grant nothing; bad-address code never appears
  a_r8_fail_no_grant: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != 3'b000) |-> (!rsp_rd && !rsp_wr && rsp_pa == '0));
  a_r8_code_legal: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_code == 3'b000 || rsp_code == 3'b100 ||
                   rsp_code == 3'b101 || rsp_code == 3'b110));
  // R7: write permission implies read permission
  a_r7_wr_implies_rd: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wr) |-> rsp_rd);
  // R6: a store that matches must be writable; a load never gets DIRTY
  a_r6_store_match_writable: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_code != 3'b000 || rsp_wr));
  a_r6_load_never_dirty: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> (rsp_code != 3'b100));
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
  .rsp_code(rsp_code)
);

// File: tb/tb_tlb_pair_lookup.sv
module tb_tlb_pair_lookup;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_tag = '0, wr_mask = '0, wr_pfn0 = '0, wr_pfn1 = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0, wr_v0 = 1'b0, wr_v1 = 1'b0, wr_d0 = 1'b0, wr_d1 = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic        rsp_valid, rsp_rd, rsp_wr;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_pair_lookup dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1), .wr_v0(wr_v0), .wr_v1(wr_v1),
    .wr_d0(wr_d0), .wr_d1(wr_d1), .req_valid(req_valid), .req_va(req_va),
    .req_asid(req_asid), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_code(rsp_code)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] va;
    logic [7:0]  asid;
    logic        wr;
    logic [2:0]  code;
    logic [31:0] pa;
    logic        rd;
    logic        wp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{8'd4, 32'h0040_0123, 8'd5, 1'b0, 3'b000, 32'h1000_0123, 1'b1, 1'b1}, // R4 even half, 4K
    '{8'd6, 32'h0040_1ABC, 8'd5, 1'b1, 3'b100, 32'h0,         1'b0, 1'b0}, // R6 store to clean
    '{8'd6, 32'h0040_1ABC, 8'd5, 1'b0, 3'b000, 32'h2000_0ABC, 1'b1, 1'b0}, // R6 load of clean
    '{8'd2, 32'h0040_0123, 8'd6, 1'b0, 3'b110, 32'h0,         1'b0, 1'b0}, // R2 ASID mismatch
    '{8'd2, 32'h0080_5678, 8'd3, 1'b1, 3'b000, 32'h3001_1678, 1'b1, 1'b1}, // R2 global, 16K odd
    '{8'd5, 32'h0080_2345, 8'd3, 1'b0, 3'b101, 32'h0,         1'b0, 1'b0}, // R5 invalid load
    '{8'd5, 32'h0080_2345, 8'd9, 1'b1, 3'b101, 32'h0,         1'b0, 1'b0}, // R5 invalid store
    '{8'd3, 32'h0300_0010, 8'd7, 1'b0, 3'b000, 32'h5000_0010, 1'b1, 1'b1}, // R3 16M odd
    '{8'd7, 32'h02AB_CDEF, 8'd7, 1'b1, 3'b000, 32'h40AB_CDEF, 1'b1, 1'b1}, // R7 16M even store
    '{8'd3, 32'h0101_2345, 8'd7, 1'b0, 3'b000, 32'h6001_2345, 1'b1, 1'b1}, // R3 64K odd
    '{8'd9, 32'h0C00_0040, 8'd1, 1'b0, 3'b000, 32'h7000_0040, 1'b1, 1'b1}, // R9 lowest index
    '{8'd8, 32'h0900_0000, 8'd1, 1'b0, 3'b110, 32'h0,         1'b0, 1'b0}, // R8 no entry
    '{8'd3, 32'h0040_2000, 8'd5, 1'b0, 3'b110, 32'h0,         1'b0, 1'b0}  // R3 past the 4K pair
  };

  task automatic put_entry(input int idx, input logic [31:0] tag, input logic [31:0] mask,
                           input logic [7:0] asid, input logic g,
                           input logic [31:0] p0, input logic [31:0] p1,
                           input logic v0, input logic v1, input logic d0, input logic d1,
                           input bit hold);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_tag = tag; wr_mask = mask; wr_asid = asid;
    wr_global = g; wr_pfn0 = p0; wr_pfn1 = p1; wr_v0 = v0; wr_v1 = v1; wr_d0 = d0; wr_d1 = d1;
    if (!hold) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic wr,
                        input bit same_cycle);
    if (!same_cycle) @(negedge clk);
    req_valid = 1'b1; req_va = va; req_asid = asid; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic [2:0] code, input logic [31:0] pa,
                            input logic rd, input logic wp);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_code !== code || rsp_pa !== pa ||
        rsp_rd !== rd || rsp_wr !== wp) begin
      errors++;
      $display("FAIL %s: got v=%b code=%b pa=%h rd=%b wr=%b, expected v=1 code=%b pa=%h rd=%b wr=%b",
               tag, rsp_valid, rsp_code, rsp_pa, rsp_rd, rsp_wr, code, pa, rd, wp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: no response while in reset
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got rsp_valid=%b, expected 0", rsp_valid);
    end
    rst = 1'b0;
    // R1: cleared entry matches va 0 / asid 0 but is invalid
    lookup(32'h0, 8'd0, 1'b0, 0);
    expect_rsp("R1", 3'b101, 32'h0, 1'b0, 1'b0);
    lookup(32'h0040_0000, 8'd5, 1'b0, 0);
    expect_rsp("R8", 3'b110, 32'h0, 1'b0, 1'b0);
    // R10: idle cycle drops rsp_valid
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: got rsp_valid=%b, expected 0", rsp_valid);
    end

    put_entry(0, 32'h0040_0000, 32'h0000_0000, 8'd5, 1'b0, 32'h1000_0000, 32'h2000_0000, 1, 1, 1, 0, 0);
    put_entry(1, 32'h0080_0000, 32'h0000_6000, 8'd9, 1'b1, 32'h3000_0000, 32'h3001_0000, 0, 1, 0, 1, 0);
    put_entry(2, 32'h0200_0000, 32'h01FF_E000, 8'd7, 1'b0, 32'h4000_0000, 32'h5000_0000, 1, 1, 1, 1, 0);
    put_entry(3, 32'h0100_0000, 32'h0001_E000, 8'd7, 1'b0, 32'h6000_0000, 32'h6001_0000, 1, 1, 1, 1, 0);
    put_entry(6, 32'h0C00_0000, 32'h0000_0000, 8'd1, 1'b0, 32'h7100_0000, 32'h0,         1, 0, 1, 0, 0);
    put_entry(5, 32'h0C00_0000, 32'h0000_0000, 8'd1, 1'b0, 32'h7000_0000, 32'h0,         1, 0, 1, 0, 0);

    for (int k = 0; k < NVEC; k++) begin
      lookup(VEC[k].va, VEC[k].asid, VEC[k].wr, 0);
      expect_rsp($sformatf("R%0d vec%0d", VEC[k].req, k), VEC[k].code, VEC[k].pa, VEC[k].rd, VEC[k].wp);
    end

    // R11: write and lookup together: lookup sees old contents
    put_entry(8, 32'h0D00_0000, 32'h0, 8'd1, 1'b0, 32'h7200_0000, 32'h0, 1, 0, 1, 0, 1);
    lookup(32'h0D00_0000, 8'd1, 1'b0, 1);
    expect_rsp("R11 same cycle", 3'b110, 32'h0, 1'b0, 1'b0);
    lookup(32'h0D00_0000, 8'd1, 1'b0, 0);
    expect_rsp("R11 after write", 3'b000, 32'h7200_0000, 1'b1, 1'b1);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule